// File: doc/BRIEF.md
# Packed Issue-Queue Wakeup Array

This block is the associative wakeup part of an out-of-order issue queue. Each entry has two tag comparator slots. An entry can hold one of two things. It can hold two independent instructions, one in each half, when each of them waits on at most one operand. It can instead hold one instruction that still waits on both operands, which then uses both comparators. Packing instructions this way lets a queue of a given capacity work with about half the comparators and much shorter tag buses.

Up to two instructions arrive per cycle. Each carries two source tags, two ready bits and an opcode identifier. The array chooses a slot for each instruction in the same cycle. It watches several result-tag buses and compares every valid broadcast against the stored waiting tags. It also compares the broadcasts against the tags of the instructions arriving in that cycle, so that no wakeup is lost. It raises a per-slot ready flag for the select logic. The select logic retires slots through a per-slot issue mask.

Top module: `pkw_wakeup_array`

## Requirements
- R1: After reset every slot is empty and `slot_rdy` is all zero. The first instruction dispatched afterwards goes to slot 0. Slot index is 2*entry + half.
- R2: An instruction is packable when at most one of its two sources is not ready. A packable instruction occupies one half-slot, which tracks its unready source tag. If both sources are ready, the half-slot is ready one edge after dispatch.
- R3: A packable instruction goes to the free half of the lowest-numbered entry that has exactly one half busy. If no such entry exists, it goes to half 0 of the lowest fully free entry.
- R4: An instruction with two unready sources needs a fully free entry (the lowest one) and is reported at its even slot. That slot becomes ready only when both source tags have been matched. The odd slot of such an entry never reports ready, and both halves stay valid or empty together.
- R5: A valid bus whose tag equals a valid slot's waiting tag sets that slot's ready state at the next edge. Matches on any of the buses count. A bus with its valid bit low has no effect. An empty slot never reports ready, and a ready slot stays ready until it is issued.
- R6: A broadcast in the same cycle as a dispatch counts as a ready source for the incoming instruction.
- R7: Dispatch is in order. `disp_ok[1]` can be set only when instruction 0 is also accepted or not offered. Acceptance and slot index are valid combinationally in the cycle of the request.
- R8: A set `iss_clr` bit empties its slot at the next edge. On the even slot of a two-source entry it empties both halves. On the odd slot of such an entry it is ignored. An entry becomes free for allocation once both halves are empty.
- R9: `slot_op` reports the opcode identifier of each occupied slot's instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_vld | input | 2 | Dispatch request per instruction (bit 1 = younger) |
| disp_src0_tag | input | 2*TAG_W | First source tag of each instruction |
| disp_src1_tag | input | 2*TAG_W | Second source tag of each instruction |
| disp_src0_rdy | input | 2 | First source already available |
| disp_src1_rdy | input | 2 | Second source already available |
| disp_op | input | 2*OP_W | Opcode identifier of each instruction |
| disp_ok | output | 2 | Instruction accepted this cycle |
| disp_slot | output | 2*SLOT_W | Slot chosen for each accepted instruction |
| bus_vld | input | NUM_BUS | Broadcast bus valid |
| bus_tag | input | NUM_BUS*TAG_W | Broadcast result tags |
| iss_clr | input | 2*NUM_ENT | Per-slot issue / clear mask |
| slot_rdy | output | 2*NUM_ENT | Per-slot ready for select |
| slot_op | output | 2*NUM_ENT*OP_W | Per-slot opcode identifier |

## Verification
`disp_ok` and `disp_slot` depend only on the current occupancy and the current inputs, so they are due in the same cycle as the request. Every other result (`slot_rdy`, `slot_op` and the occupancy change caused by a dispatch, a broadcast or an issue) is due exactly one clock edge later. The bench applies each stimulus at a falling edge. It reads the allocation outputs 1 ns later, before the rising edge. It reads the ready and opcode outputs 1 ns after that rising edge, so each check sees the value of exactly one register stage.

// File: rtl/pkw_pkg.sv
package pkw_pkg;
  typedef enum logic {
    MODE_HALF = 1'b0,
    MODE_FULL = 1'b1
  } ent_mode_e;
endpackage

// File: rtl/pkw_tag_match.sv
module pkw_tag_match #(
  parameter int TAG_W   = 6,
  parameter int NUM_BUS = 2
) (
  input  logic [TAG_W-1:0]         tag_i,
  input  logic [NUM_BUS-1:0]       bus_vld_i,
  input  logic [NUM_BUS*TAG_W-1:0] bus_tag_i,
  output logic                     hit_o
);
  logic [NUM_BUS-1:0] bus_hit;

  generate
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
      assign bus_hit[b] = bus_vld_i[b] && (bus_tag_i[b*TAG_W +: TAG_W] == tag_i);
    end
  endgenerate

  assign hit_o = |bus_hit;
endmodule

// File: rtl/pkw_alloc.sv
module pkw_alloc #(
  parameter int NUM_ENT = 4,
  localparam int NSLOT  = 2 * NUM_ENT,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0]    occ_i,
  input  logic [1:0]          req_i,
  input  logic [1:0]          pack_i,
  output logic [1:0]          ok_o,
  output logic [2*SLOT_W-1:0] slot_o
);
  always_comb begin
    logic [NSLOT-1:0]  occ;
    logic              found;
    logic [SLOT_W-1:0] pick;
    occ    = occ_i;
    ok_o   = '0;
    slot_o = '0;
    for (int d = 0; d < 2; d++) begin
      found = 1'b0;
      pick  = '0;
      if (req_i[d] && (d == 0 || ok_o[0] || !req_i[0])) begin
        if (pack_i[d]) begin
          for (int e = 0; e < NUM_ENT; e++) begin
            if (!found && (occ[2*e] ^ occ[2*e+1])) begin
              found = 1'b1;
              pick  = occ[2*e] ? SLOT_W'(2*e+1) : SLOT_W'(2*e);
            end
          end
        end
        for (int e = 0; e < NUM_ENT; e++) begin
          if (!found && !occ[2*e] && !occ[2*e+1]) begin
            found = 1'b1;
            pick  = SLOT_W'(2*e);
          end
        end
        if (found) begin
          ok_o[d]                      = 1'b1;
          slot_o[d*SLOT_W +: SLOT_W]   = pick;
          occ[pick]                    = 1'b1;
          if (!pack_i[d]) occ[pick | SLOT_W'(1)] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pkw_entry.sv
module pkw_entry
  import pkw_pkg::*;
#(
  parameter int TAG_W   = 6,
  parameter int NUM_BUS = 2,
  parameter int OP_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_BUS-1:0]       bus_vld_i,
  input  logic [NUM_BUS*TAG_W-1:0] bus_tag_i,
  input  logic [1:0]               wr_en_i,
  input  ent_mode_e                wr_mode_i,
  input  logic [2*TAG_W-1:0]       wr_tag_i,
  input  logic [1:0]               wr_rdy_i,
  input  logic [2*OP_W-1:0]        wr_op_i,
  input  logic [1:0]               clr_i,
  output logic [1:0]               vld_o,
  output logic                     full_o,
  output logic [1:0]               ready_o,
  output logic [2*OP_W-1:0]        op_o
);
  logic [1:0]         vld_q, vld_n, rdy_q, rdy_n, hit, clr_eff;
  ent_mode_e          mode_q, mode_n;
  logic [2*TAG_W-1:0] tag_q;
  logic [2*OP_W-1:0]  op_q;
  logic               st_en;

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      pkw_tag_match #(.TAG_W(TAG_W), .NUM_BUS(NUM_BUS)) u_match (
        .tag_i     (tag_q[h*TAG_W +: TAG_W]),
        .bus_vld_i (bus_vld_i),
        .bus_tag_i (bus_tag_i),
        .hit_o     (hit[h])
      );
    end
  endgenerate

  assign clr_eff[0] = clr_i[0];
  assign clr_eff[1] = (mode_q == MODE_FULL) ? clr_i[0] : clr_i[1];

  always_comb begin
    vld_n  = vld_q;
    rdy_n  = rdy_q;
    mode_n = mode_q;
    for (int h = 0; h < 2; h++) begin
      if (vld_q[h] && hit[h]) rdy_n[h] = 1'b1;
      if (clr_eff[h])         vld_n[h] = 1'b0;
      if (wr_en_i[h]) begin
        vld_n[h] = 1'b1;
        rdy_n[h] = wr_rdy_i[h];
      end
    end
    if (|wr_en_i) mode_n = wr_mode_i;
  end

  assign st_en = (|wr_en_i) || (|clr_i) || (|(hit & vld_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      rdy_q  <= '0;
      mode_q <= MODE_HALF;
    end else if (st_en) begin
      vld_q  <= vld_n;
      rdy_q  <= rdy_n;
      mode_q <= mode_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i[0]) begin
      tag_q[0 +: TAG_W] <= wr_tag_i[0 +: TAG_W];
      op_q[0 +: OP_W]   <= wr_op_i[0 +: OP_W];
    end
    if (wr_en_i[1]) begin
      tag_q[TAG_W +: TAG_W] <= wr_tag_i[TAG_W +: TAG_W];
      op_q[OP_W +: OP_W]    <= wr_op_i[OP_W +: OP_W];
    end
  end

  assign vld_o      = vld_q;
  assign full_o     = (mode_q == MODE_FULL);
  assign ready_o[0] = vld_q[0] && rdy_q[0] && ((mode_q == MODE_HALF) || rdy_q[1]);
  assign ready_o[1] = vld_q[1] && rdy_q[1] && (mode_q == MODE_HALF);
  assign op_o       = op_q;
endmodule

// File: rtl/pkw_wakeup_array.sv
module pkw_wakeup_array
  import pkw_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int TAG_W   = 6,
  parameter int NUM_BUS = 2,
  parameter int OP_W    = 4,
  localparam int NSLOT  = 2 * NUM_ENT,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               disp_vld,
  input  logic [2*TAG_W-1:0]       disp_src0_tag,
  input  logic [2*TAG_W-1:0]       disp_src1_tag,
  input  logic [1:0]               disp_src0_rdy,
  input  logic [1:0]               disp_src1_rdy,
  input  logic [2*OP_W-1:0]        disp_op,
  output logic [1:0]               disp_ok,
  output logic [2*SLOT_W-1:0]      disp_slot,
  input  logic [NUM_BUS-1:0]       bus_vld,
  input  logic [NUM_BUS*TAG_W-1:0] bus_tag,
  input  logic [NSLOT-1:0]         iss_clr,
  output logic [NSLOT-1:0]         slot_rdy,
  output logic [NSLOT*OP_W-1:0]    slot_op
);
  logic [1:0]         byp0, byp1, eff0, eff1, pack, trk_rdy;
  logic [2*TAG_W-1:0] trk_tag;
  logic [NSLOT-1:0]   slot_vld;
  logic [NUM_ENT-1:0] ent_full;

  // Same-cycle broadcast bypass on the incoming source tags.
  generate
    for (genvar d = 0; d < 2; d++) begin : g_disp
      pkw_tag_match #(.TAG_W(TAG_W), .NUM_BUS(NUM_BUS)) u_byp0 (
        .tag_i(disp_src0_tag[d*TAG_W +: TAG_W]), .bus_vld_i(bus_vld),
        .bus_tag_i(bus_tag), .hit_o(byp0[d]));
      pkw_tag_match #(.TAG_W(TAG_W), .NUM_BUS(NUM_BUS)) u_byp1 (
        .tag_i(disp_src1_tag[d*TAG_W +: TAG_W]), .bus_vld_i(bus_vld),
        .bus_tag_i(bus_tag), .hit_o(byp1[d]));
      assign eff0[d]    = disp_src0_rdy[d] | byp0[d];
      assign eff1[d]    = disp_src1_rdy[d] | byp1[d];
      assign pack[d]    = eff0[d] | eff1[d];
      assign trk_rdy[d] = eff0[d] & eff1[d];
      assign trk_tag[d*TAG_W +: TAG_W] = eff0[d] ? disp_src1_tag[d*TAG_W +: TAG_W]
                                                 : disp_src0_tag[d*TAG_W +: TAG_W];
    end
  endgenerate

  pkw_alloc #(.NUM_ENT(NUM_ENT)) u_alloc (
    .occ_i  (slot_vld),
    .req_i  (disp_vld),
    .pack_i (pack),
    .ok_o   (disp_ok),
    .slot_o (disp_slot)
  );

  generate
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      logic [1:0]         wr_en, wr_rdy;
      ent_mode_e          wr_mode;
      logic [2*TAG_W-1:0] wr_tag;
      logic [2*OP_W-1:0]  wr_op;

      always_comb begin
        wr_en   = '0;
        wr_rdy  = '0;
        wr_mode = MODE_HALF;
        wr_tag  = '0;
        wr_op   = '0;
        for (int d = 0; d < 2; d++) begin
          if (disp_ok[d]) begin
            if (pack[d]) begin
              for (int h = 0; h < 2; h++) begin
                if (disp_slot[d*SLOT_W +: SLOT_W] == SLOT_W'(2*e+h)) begin
                  wr_en[h]                = 1'b1;
                  wr_rdy[h]               = trk_rdy[d];
                  wr_tag[h*TAG_W +: TAG_W] = trk_tag[d*TAG_W +: TAG_W];
                  wr_op[h*OP_W +: OP_W]   = disp_op[d*OP_W +: OP_W];
                end
              end
            end else if (disp_slot[d*SLOT_W +: SLOT_W] == SLOT_W'(2*e)) begin
              wr_en   = 2'b11;
              wr_mode = MODE_FULL;
              wr_rdy  = {eff1[d], eff0[d]};
              wr_tag  = {disp_src1_tag[d*TAG_W +: TAG_W], disp_src0_tag[d*TAG_W +: TAG_W]};
              wr_op   = {2{disp_op[d*OP_W +: OP_W]}};
            end
          end
        end
      end

      pkw_entry #(.TAG_W(TAG_W), .NUM_BUS(NUM_BUS), .OP_W(OP_W)) u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_vld_i (bus_vld),
        .bus_tag_i (bus_tag),
        .wr_en_i   (wr_en),
        .wr_mode_i (wr_mode),
        .wr_tag_i  (wr_tag),
        .wr_rdy_i  (wr_rdy),
        .wr_op_i   (wr_op),
        .clr_i     (iss_clr[2*e +: 2]),
        .vld_o     (slot_vld[2*e +: 2]),
        .full_o    (ent_full[e]),
        .ready_o   (slot_rdy[2*e +: 2]),
        .op_o      (slot_op[2*e*OP_W +: 2*OP_W])
      );
    end
  endgenerate
endmodule

// File: rtl/pkw_wakeup_chk.sv
module pkw_wakeup_chk #(
  parameter int NUM_ENT = 4,
  localparam int NSLOT  = 2 * NUM_ENT
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       disp_vld,
  input logic [1:0]       disp_ok,
  input logic [NSLOT-1:0] iss_clr,
  input logic [NSLOT-1:0] slot_rdy,
  input logic [NSLOT-1:0] slot_vld,
  input logic [NUM_ENT-1:0] ent_full
);
  // R7
  disp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_ok[1] && disp_vld[0]) |-> disp_ok[0]);

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      // R5
      rdy_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_rdy[s] |-> slot_vld[s]);
      // R5
      rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_rdy[s] && !iss_clr[s]) |=> slot_rdy[s]);
    end
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      // R4
      full_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_full[e] |-> (slot_vld[2*e] == slot_vld[2*e+1]));
      // R8
      iss_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_clr[2*e] && slot_vld[2*e]) |=> !slot_vld[2*e]);
    end
  endgenerate
endmodule

bind pkw_wakeup_array pkw_wakeup_chk #(.NUM_ENT(NUM_ENT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .disp_vld (disp_vld),
  .disp_ok  (disp_ok),
  .iss_clr  (iss_clr),
  .slot_rdy (slot_rdy),
  .slot_vld (slot_vld),
  .ent_full (ent_full)
);

// File: tb/test_pkw_wakeup_array.sv
`timescale 1ns/1ps
module test_pkw_wakeup_array;
  localparam int NUM_ENT = 4;
  localparam int TAG_W   = 6;
  localparam int NUM_BUS = 2;
  localparam int OP_W    = 4;
  localparam int NSLOT   = 2 * NUM_ENT;
  localparam int SLOT_W  = $clog2(NSLOT);

  typedef struct packed {
    logic [1:0] dv;
    logic [5:0] a0, a1;
    logic [1:0] ar;
    logic [5:0] b0, b1;
    logic [1:0] br;
    logic [3:0] op0, op1;
    logic [1:0] bv;
    logic [5:0] bt0, bt1;
    logic [7:0] clr;
    logic [1:0] eok;
    logic [2:0] es0, es1;
    logic [7:0] erdy;
  } step_t;

  localparam int NROW = 13;
  // ar/br: bit0 = first source ready, bit1 = second source ready
  localparam step_t TBL [NROW] = '{
    '{2'b11, 6'd5, 6'd6, 2'b01, 6'd7, 6'd8, 2'b00, 4'd1, 4'd2, 2'b00, 6'd0, 6'd0, 8'h00, 2'b11, 3'd0, 3'd2, 8'h00}, // R2 R4 R1
    '{2'b01, 6'd9, 6'd10, 2'b11, 6'd0, 6'd0, 2'b00, 4'd3, 4'd0, 2'b01, 6'd6, 6'd0, 8'h00, 2'b01, 3'd1, 3'd0, 8'h03}, // R3 R5
    '{2'b11, 6'd7, 6'd11, 2'b00, 6'd12, 6'd13, 2'b00, 4'd4, 4'd5, 2'b01, 6'd7, 6'd0, 8'h00, 2'b11, 3'd4, 3'd6, 8'h03}, // R6 R4
    '{2'b01, 6'd1, 6'd2, 2'b01, 6'd0, 6'd0, 2'b00, 4'd6, 4'd0, 2'b11, 6'd11, 6'd8, 8'h00, 2'b01, 3'd5, 3'd0, 8'h17}, // R3 R5
    '{2'b11, 6'd3, 6'd4, 2'b00, 6'd16, 6'd17, 2'b11, 4'd7, 4'd8, 2'b00, 6'd0, 6'd0, 8'h05, 2'b00, 3'd0, 3'd0, 8'h12}, // R8
    '{2'b11, 6'd3, 6'd4, 2'b00, 6'd14, 6'd15, 2'b10, 4'd7, 4'd8, 2'b01, 6'd2, 6'd0, 8'h00, 2'b11, 3'd2, 3'd0, 8'h32}, // R8 R3
    '{2'b00, 6'd0, 6'd0, 2'b00, 6'd0, 6'd0, 2'b00, 4'd0, 4'd0, 2'b11, 6'd3, 6'd4, 8'h00, 2'b00, 3'd0, 3'd0, 8'h36}, // R4
    '{2'b00, 6'd0, 6'd0, 2'b00, 6'd0, 6'd0, 2'b00, 4'd0, 4'd0, 2'b00, 6'd14, 6'd0, 8'h08, 2'b00, 3'd0, 3'd0, 8'h36}, // R5 R8
    '{2'b00, 6'd0, 6'd0, 2'b00, 6'd0, 6'd0, 2'b00, 4'd0, 4'd0, 2'b00, 6'd0, 6'd0, 8'h02, 2'b00, 3'd0, 3'd0, 8'h34}, // R8
    '{2'b11, 6'd20, 6'd21, 2'b00, 6'd22, 6'd23, 2'b10, 4'd0, 4'd0, 2'b01, 6'd9, 6'd0, 8'h00, 2'b00, 3'd0, 3'd0, 8'h34}, // R7 R5
    '{2'b10, 6'd0, 6'd0, 2'b00, 6'd22, 6'd23, 2'b10, 4'd0, 4'd9, 2'b00, 6'd0, 6'd0, 8'h00, 2'b10, 3'd0, 3'd1, 8'h34}, // R7 R3
    '{2'b00, 6'd0, 6'd0, 2'b00, 6'd0, 6'd0, 2'b00, 4'd0, 4'd0, 2'b00, 6'd0, 6'd0, 8'hFF, 2'b00, 3'd0, 3'd0, 8'h00}, // R8
    '{2'b11, 6'd20, 6'd21, 2'b00, 6'd24, 6'd25, 2'b00, 4'd10, 4'd11, 2'b00, 6'd0, 6'd0, 8'h00, 2'b11, 3'd0, 3'd2, 8'h00} // R4 R8
  };

  logic                     clk, rst_n;
  logic [1:0]               disp_vld, disp_src0_rdy, disp_src1_rdy, disp_ok;
  logic [2*TAG_W-1:0]       disp_src0_tag, disp_src1_tag;
  logic [2*OP_W-1:0]        disp_op;
  logic [2*SLOT_W-1:0]      disp_slot;
  logic [NUM_BUS-1:0]       bus_vld;
  logic [NUM_BUS*TAG_W-1:0] bus_tag;
  logic [NSLOT-1:0]         iss_clr, slot_rdy;
  logic [NSLOT*OP_W-1:0]    slot_op;
  int total, bad;

  pkw_wakeup_array #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W), .NUM_BUS(NUM_BUS), .OP_W(OP_W))
  i_pkw_wakeup_array (
    .clk(clk), .rst_n(rst_n), .disp_vld(disp_vld), .disp_src0_tag(disp_src0_tag),
    .disp_src1_tag(disp_src1_tag), .disp_src0_rdy(disp_src0_rdy), .disp_src1_rdy(disp_src1_rdy),
    .disp_op(disp_op), .disp_ok(disp_ok), .disp_slot(disp_slot), .bus_vld(bus_vld),
    .bus_tag(bus_tag), .iss_clr(iss_clr), .slot_rdy(slot_rdy), .slot_op(slot_op));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_vld = '0; disp_src0_tag = '0; disp_src1_tag = '0; disp_src0_rdy = '0;
    disp_src1_rdy = '0; disp_op = '0; bus_vld = '0; bus_tag = '0; iss_clr = '0;
  endtask

  task automatic apply(input step_t s, input int row);
    @(negedge clk);
    disp_vld = s.dv; disp_src0_tag = {s.b0, s.a0}; disp_src1_tag = {s.b1, s.a1};
    disp_src0_rdy = {s.br[0], s.ar[0]}; disp_src1_rdy = {s.br[1], s.ar[1]};
    disp_op = {s.op1, s.op0}; bus_vld = s.bv; bus_tag = {s.bt1, s.bt0}; iss_clr = s.clr;
    #1;
    check(disp_ok == s.eok, $sformatf("R7 R2 row %0d disp_ok", row), 32'(disp_ok), 32'(s.eok));
    if (s.eok[0]) check(disp_slot[2:0] == s.es0, $sformatf("R3 R4 row %0d slot0", row),
                        32'(disp_slot[2:0]), 32'(s.es0));
    if (s.eok[1]) check(disp_slot[5:3] == s.es1, $sformatf("R3 R4 row %0d slot1", row),
                        32'(disp_slot[5:3]), 32'(s.es1));
    @(posedge clk); #1;
    check(slot_rdy == s.erdy, $sformatf("R5 R8 row %0d slot_rdy", row), 32'(slot_rdy), 32'(s.erdy));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(slot_rdy == '0, "R1 reset slot_rdy", 32'(slot_rdy), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) apply(TBL[i], i);

    @(negedge clk); idle();
    // R9: opcode ids of the two two-source entries from the last row
    check(slot_op[0 +: OP_W] == 4'd10, "R9 slot0 op", 32'(slot_op[0 +: OP_W]), 32'd10);
    check(slot_op[2*OP_W +: OP_W] == 4'd11, "R9 slot2 op", 32'(slot_op[2*OP_W +: OP_W]), 32'd11);

    // R6: both sources broadcast in the dispatch cycle -> packed, ready next edge
    disp_vld = 2'b01; disp_src0_tag = {6'd0, 6'd30}; disp_src1_tag = {6'd0, 6'd31};
    disp_op = {4'd0, 4'd12}; bus_vld = 2'b11; bus_tag = {6'd31, 6'd30};
    #1;
    check(disp_ok == 2'b01 && disp_slot[2:0] == 3'd4, "R6 bypass slot", 32'(disp_slot[2:0]), 32'd4);
    @(posedge clk); #1;
    check(slot_rdy == 8'h10, "R6 bypass ready", 32'(slot_rdy), 32'h10);
    check(slot_op[4*OP_W +: OP_W] == 4'd12, "R9 slot4 op", 32'(slot_op[4*OP_W +: OP_W]), 32'd12);

    // R1: asynchronous reset mid-run empties every slot
    @(negedge clk); idle(); rst_n = 1'b0;
    #1;
    check(slot_rdy == '0, "R1 mid reset slot_rdy", 32'(slot_rdy), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    disp_vld = 2'b01; disp_src0_rdy = 2'b01; disp_src1_rdy = 2'b01; disp_op = {4'd0, 4'd5};
    #1;
    check(disp_ok == 2'b01 && disp_slot[2:0] == 3'd0, "R1 first slot after reset",
          32'(disp_slot[2:0]), 32'd0);
    @(posedge clk); #1;
    check(slot_rdy == 8'h01, "R2 ready-at-dispatch", 32'(slot_rdy), 32'h01);
    @(negedge clk); idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule